// File: doc/BRIEF.md
# Cluster-Format Pixel Stream Decoder

This block turns the 16-bit body words of a clustering-engine output frame into one pixel record per pixel word. Two kinds of body word are mixed in the stream. A row word (bit 15 clear) sets a running row address and gives the context for the pixels after it: a chip index, two bits of energy-loss information and a start-of-cluster marker. A pixel word (bit 15 set) gives a column and an ADC value. A pixel word can also advance the running row by one, so a row that lies between two row words is implied and is never sent.

Words arrive on a valid/ready stream that carries start-of-frame and end-of-frame markers. The first word of a frame is the header. Its type field is checked, and a frame of any other type is skipped. The second word is the trigger tag; it is consumed without being decoded. The remaining words up to and including the end-of-frame word are decoded. Records leave on a valid/ready stream through a single output register.

Top module: `clus_pix_dec`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `err_orphan` are 0 and `in_ready` is 1.
- R2: A row word (bit 15 = 0) loads the running row from bits 9:0 and produces no record. A later pixel word (bit 15 = 1, bit 14 = 0) produces one record: the running row, column = bits 13:8, ADC = bits 7:0. The record is visible in the cycle after the word is accepted.
- R3: A pixel word with bit 14 = 1 adds one to the running row before its record is formed. The record carries the new row, and later pixels use it.
- R4: An increment from row 1023 wraps to row 0.
- R5: A row word with bit 14 = 1 sets `out_soc` on the first pixel record after it and on no other record. A row word with bit 14 = 0 gives no marker.
- R6: Every pixel record carries the chip index (bits 11:10) and energy-loss field (bits 13:12) of the most recent row word in the frame.
- R7: A pixel word that arrives before any row word in the current frame produces no record and sets `err_orphan`. The flag stays set until reset.
- R8: A frame whose first word (marked by `in_sof`) has a type field in bits 14:11 other than 4'b0001 produces no records up to its end-of-frame word.
- R9: The second word of an accepted frame is the trigger tag. It produces no record and changes no running state, even when it is shaped like a pixel word.
- R10: Every start of frame clears the running row, the context and the seen-row state, so a pixel word before the new frame's first row word counts as an orphan.
- R11: While `out_valid` = 1 and `out_ready` = 0, the record is held unchanged and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can accept a word |
| in_data | input | 16 | Input word |
| in_sof | input | 1 | Word is the first of a frame (header) |
| in_eof | input | 1 | Word is the last of a frame |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Sink accepts record |
| out_row | output | 10 | Row address of the pixel |
| out_col | output | 6 | Column address |
| out_adc | output | 8 | ADC value |
| out_chip | output | 2 | Chip index from the governing row word |
| out_dedx | output | 2 | Energy-loss field from the governing row word |
| out_soc | output | 1 | First pixel of a cluster |
| err_orphan | output | 1 | Sticky: a pixel word came before any row word |

## Verification
The hardest case to reach from the ports is a pixel word that is accepted in the same cycle as the handshake that drains a stalled record. The old record and the new one then swap in a single edge, and a slip there would lose one of them or send one twice. The stimulus holds `out_ready` low with a second pixel word waiting at the input, then raises `out_ready`. The bench checks that the held record stays unchanged while stalled and that the waiting pixel appears on the very next cycle. Row wrap-around is reached through a row word at 1023 followed by an incrementing pixel. The orphan flag is reached through a frame whose body starts with a pixel word.

// File: rtl/cpd_pkg.sv
// Package: shared widths, frame type code and the pixel record type
// for the cluster-format pixel decoder.
package cpd_pkg;
    localparam int WORD_W  = 16;
    localparam int ROW_W   = 10;
    localparam int COL_W   = 6;
    localparam int ADC_W   = 8;
    localparam int CHIP_W  = 2;
    localparam int DEDX_W  = 2;
    localparam int TYPE_W  = 4;
    localparam int TYPE_LO = 11;
    localparam logic [TYPE_W-1:0] CLUS_TYPE = 4'b0001;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [ADC_W-1:0]  adc;
        logic [CHIP_W-1:0] chip;
        logic [DEDX_W-1:0] dedx;
        logic              soc;
    } pix_rec_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_TAG  = 2'd1,
        FR_BODY = 2'd2,
        FR_SKIP = 2'd3
    } frame_st_t;
endpackage

// File: rtl/cpd_frame_ctl.sv
// Module: cpd_frame_ctl
// Follows frame position: header, trigger tag, body, or skipped frame.
// Assumes: acc is the input handshake; sof marks the header word and
// takes priority in any state; eof closes the frame after its word.
module cpd_frame_ctl
    import cpd_pkg::*;
#(
    parameter int TW = TYPE_W,
    parameter logic [TW-1:0] WANT_TYPE = CLUS_TYPE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          sof,
    input  logic          eof,
    input  logic [TW-1:0] hdr_type,
    output logic          frame_start,
    output logic          body_word
);
    frame_st_t st_q, st_d;

    // Frame-position next-state logic.
    always_comb begin
        st_d = st_q;
        if (acc) begin
            if (sof) begin
                if (eof)                         st_d = FR_IDLE;
                else if (hdr_type == WANT_TYPE)  st_d = FR_TAG;
                else                             st_d = FR_SKIP;
            end else begin
                case (st_q)
                    FR_TAG:  st_d = eof ? FR_IDLE : FR_BODY;
                    FR_BODY: st_d = eof ? FR_IDLE : FR_BODY;
                    FR_SKIP: st_d = eof ? FR_IDLE : FR_SKIP;
                    default: st_d = FR_IDLE;
                endcase
            end
        end
    end

    // Frame-position register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    assign frame_start = acc && sof;
    assign body_word   = acc && !sof && (st_q == FR_BODY);
endmodule

// File: rtl/cpd_row_track.sv
// Module: cpd_row_track
// Holds the running row and row-word context, and forms pixel records.
// Assumes: body_word is asserted only for accepted body words;
// frame_start clears the running state; err is cleared by reset only.
module cpd_row_track
    import cpd_pkg::*;
#(
    parameter int RW = ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              body_word,
    input  logic [WORD_W-1:0] word,
    output logic              emit,
    output pix_rec_t          rec,
    output logic              err
);
    localparam int FLAG_B = WORD_W - 1;
    localparam int AUX_B  = WORD_W - 2;

    logic [RW-1:0]     row_q;
    logic [CHIP_W-1:0] chip_q;
    logic [DEDX_W-1:0] dedx_q;
    logic              soc_q;
    logic              seen_q;
    logic              err_q;

    logic              is_pix, is_sor, orphan;
    logic [RW-1:0]     row_nx;

    // Word classification and the (possibly incremented) row.
    always_comb begin
        is_pix = body_word && word[FLAG_B];
        is_sor = body_word && !word[FLAG_B];
        orphan = is_pix && !seen_q;
        row_nx = row_q + {{(RW-1){1'b0}}, word[AUX_B]};
    end

    // Running row and context registers.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            row_q  <= '0;
            chip_q <= '0;
            dedx_q <= '0;
            soc_q  <= 1'b0;
            seen_q <= 1'b0;
        end else if (is_sor) begin
            row_q  <= word[RW-1:0];
            chip_q <= word[RW+CHIP_W-1:RW];
            dedx_q <= word[RW+CHIP_W+DEDX_W-1:RW+CHIP_W];
            soc_q  <= word[AUX_B];
            seen_q <= 1'b1;
        end else if (is_pix && seen_q) begin
            row_q  <= row_nx;
            soc_q  <= 1'b0;
        end
    end

    // Sticky orphan-pixel flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (orphan) err_q <= 1'b1;
    end

    assign emit     = is_pix && seen_q;
    assign rec.row  = row_nx;
    assign rec.col  = word[COL_W+ADC_W-1:ADC_W];
    assign rec.adc  = word[ADC_W-1:0];
    assign rec.chip = chip_q;
    assign rec.dedx = dedx_q;
    assign rec.soc  = soc_q;
    assign err      = err_q;
endmodule

// File: rtl/cpd_out_stage.sv
// Module: cpd_out_stage
// Single output register for pixel records, with valid/ready.
// Assumes: load is only asserted when the slot is free or draining.
module cpd_out_stage
    import cpd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  pix_rec_t rec_in,
    input  logic     out_ready,
    output logic     out_valid,
    output pix_rec_t rec_out
);
    // Valid flag: set on load, cleared when drained.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (load)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Record payload: captured on load only.
    always_ff @(posedge clk) begin
        if (!rst_n)    rec_out <= '0;
        else if (load) rec_out <= rec_in;
    end
endmodule

// File: rtl/clus_pix_dec.sv
// Module: clus_pix_dec
// Top of the cluster-format pixel decoder: frame tracking, running-row
// decode and a registered output stage.
// Assumes: one word per handshake; the stream stalls as a whole while
// a record waits for the sink.
module clus_pix_dec
    import cpd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [9:0]  out_row,
    output logic [5:0]  out_col,
    output logic [7:0]  out_adc,
    output logic [1:0]  out_chip,
    output logic [1:0]  out_dedx,
    output logic        out_soc,
    output logic        err_orphan
);
    logic     acc, frame_start, body_word, emit;
    pix_rec_t rec_d, rec_q;

    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;

    cpd_frame_ctl u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (acc),
        .sof         (in_sof),
        .eof         (in_eof),
        .hdr_type    (in_data[TYPE_LO+TYPE_W-1:TYPE_LO]),
        .frame_start (frame_start),
        .body_word   (body_word)
    );

    cpd_row_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .body_word   (body_word),
        .word        (in_data),
        .emit        (emit),
        .rec         (rec_d),
        .err         (err_orphan)
    );

    cpd_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (emit),
        .rec_in    (rec_d),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .rec_out   (rec_q)
    );

    assign out_row  = rec_q.row;
    assign out_col  = rec_q.col;
    assign out_adc  = rec_q.adc;
    assign out_chip = rec_q.chip;
    assign out_dedx = rec_q.dedx;
    assign out_soc  = rec_q.soc;
endmodule

// File: rtl/cpd_checker.sv
// Module: cpd_checker
// Port-level properties of the pixel decoder, bound to the top.
module cpd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] in_data,
    input logic        in_sof,
    input logic        out_valid,
    input logic        out_ready,
    input logic [9:0]  out_row,
    input logic [5:0]  out_col,
    input logic [7:0]  out_adc,
    input logic [1:0]  out_chip,
    input logic [1:0]  out_dedx,
    input logic        out_soc,
    input logic        err_orphan
);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row) &&
        $stable(out_col) && $stable(out_adc) && $stable(out_chip) &&
        $stable(out_dedx) && $stable(out_soc)));

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_orphan |=> err_orphan);

    p_orphan_norec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_orphan) |-> !out_valid);

    p_rec_from_pixel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && !in_sof && in_data[15]));
endmodule

bind clus_pix_dec cpd_checker u_cpd_checker (.*);

// File: tb/clus_pix_dec_tb_top.sv
module clus_pix_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = 16'h0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [9:0]  out_row;
    logic [5:0]  out_col;
    logic [7:0]  out_adc;
    logic [1:0]  out_chip;
    logic [1:0]  out_dedx;
    logic        out_soc;
    logic        err_orphan;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    clus_pix_dec dut_i (.*);

    // Vector: sof, eof, word, exp_valid, row, col, adc, chip, dedx, soc
    localparam int NV = 19;
    localparam logic [47:0] VEC [NV] = '{
        {1'b1,1'b0,16'h0800, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0}, // header ok
        {1'b0,1'b0,16'hC5AB, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0}, // R9 tag
        {1'b0,1'b0,16'h6405, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0}, // row 5
        {1'b0,1'b0,16'h8311, 1'b1,10'd5,  6'd3, 8'h11,2'd1,2'd2,1'b1}, // R2 R5 R6
        {1'b0,1'b0,16'hC422, 1'b1,10'd6,  6'd4, 8'h22,2'd1,2'd2,1'b0}, // R3 R5
        {1'b0,1'b0,16'hBFFF, 1'b1,10'd6,  6'd63,8'hFF,2'd1,2'd2,1'b0}, // R3 keep
        {1'b0,1'b0,16'h1FFF, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0}, // row 1023
        {1'b0,1'b0,16'hC000, 1'b1,10'd0,  6'd0, 8'h00,2'd3,2'd1,1'b0}, // R4 wrap
        {1'b0,1'b1,16'hC105, 1'b1,10'd1,  6'd1, 8'h05,2'd3,2'd1,1'b0}, // R3
        {1'b1,1'b0,16'h0000, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0}, // R8 bad type
        {1'b0,1'b0,16'h0000, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0},
        {1'b0,1'b0,16'h4010, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0},
        {1'b0,1'b1,16'h8101, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0}, // R8
        {1'b1,1'b0,16'h0800, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0},
        {1'b0,1'b0,16'h0000, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0},
        {1'b0,1'b0,16'h0002, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0},
        {1'b0,1'b0,16'h8207, 1'b1,10'd2,  6'd2, 8'h07,2'd0,2'd0,1'b0}, // R5 none
        {1'b0,1'b0,16'h4C09, 1'b0,10'd0,  6'd0, 8'h00,2'd0,2'd0,1'b0},
        {1'b0,1'b1,16'h8A01, 1'b1,10'd9,  6'd10,8'h01,2'd3,2'd0,1'b1}  // R5 R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_rec(input string req, input logic [9:0] r, input logic [5:0] c,
                           input logic [7:0] a, input logic [1:0] ch, input logic [1:0] d,
                           input logic s);
        chk(req, {out_valid, out_row, out_col, out_adc, out_chip, out_dedx, out_soc},
            {1'b1, r, c, a, ch, d, s});
    endtask

    // Drive one word at the falling edge; results are seen one cycle later.
    task automatic put(input logic sof, input logic eof, input logic [15:0] w);
        in_valid = 1'b1; in_sof = sof; in_eof = eof; in_data = w;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 err_orphan", err_orphan, 0);
        chk("R1 in_ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: one word per cycle, output checked a cycle later.
        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            put(v[47], v[46], v[45:30]);
            if (v[29])
                chk_rec($sformatf("R2/R3/R4/R5/R6 vec %0d", i), v[28:19], v[18:13],
                        v[12:5], v[4:3], v[2:1], v[0]);
            else
                chk($sformatf("R8/R9 no record vec %0d", i), out_valid, 0);
        end
        chk("R7 no error yet", err_orphan, 0);

        // R7: orphan pixel in a fresh frame.
        put(1'b1, 1'b0, 16'h0800);
        put(1'b0, 1'b0, 16'h0000);
        put(1'b0, 1'b0, 16'h8105);
        chk("R7 orphan dropped", out_valid, 0);
        chk("R7 err set", err_orphan, 1);
        put(1'b0, 1'b0, 16'h0001);
        put(1'b0, 1'b1, 16'h8000);
        chk_rec("R7 decode after row", 10'd1, 6'd0, 8'h00, 2'd0, 2'd0, 1'b0);
        chk("R7 err sticky", err_orphan, 1);

        // R10: state cleared at start of frame, so first pixel is orphan.
        put(1'b1, 1'b0, 16'h0800);
        put(1'b0, 1'b0, 16'h0000);
        put(1'b0, 1'b1, 16'hC123);
        chk("R10 no record before row word", out_valid, 0);

        // R1: reset clears the sticky flag.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 err cleared by reset", err_orphan, 0);
        @(negedge clk);

        // R11: backpressure with a waiting word released in the same edge.
        out_ready = 1'b0;
        put(1'b1, 1'b0, 16'h0800);
        put(1'b0, 1'b0, 16'h0000);
        put(1'b0, 1'b0, 16'h2C20);
        put(1'b0, 1'b0, 16'h8A3C);
        chk_rec("R11 first record", 10'd32, 6'd10, 8'h3C, 2'd3, 2'd2, 1'b0);
        chk("R11 in_ready low", in_ready, 0);
        in_valid = 1'b1; in_data = 16'hC5AA; in_eof = 1'b1;
        @(negedge clk);
        chk_rec("R11 held", 10'd32, 6'd10, 8'h3C, 2'd3, 2'd2, 1'b0);
        @(negedge clk);
        chk_rec("R11 still held", 10'd32, 6'd10, 8'h3C, 2'd3, 2'd2, 1'b0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        chk_rec("R11 R3 next record", 10'd33, 6'd5, 8'hAA, 2'd3, 2'd2, 1'b0);
        @(negedge clk);
        chk("R11 drained", out_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule